// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate-Divide Unit

This block performs 32-bit integer multiplication and signed division for a processor core. It holds two result registers, HI and LO, which together form one 64-bit value with HI as the upper half. Multiplies overwrite that value. Multiply-add and multiply-subtract fold a fresh product into it. A divide places the quotient in LO and the remainder in HI.

Requests arrive on a valid/ready channel carrying an opcode and two operands. The unit accepts a request at a rising edge only when `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold the request steady, and the request is taken once `req_ready` returns. Multiplies finish at their acceptance edge. A divide runs iteratively and drives `busy` high until its result has been written, and `req_ready` is low for the whole of that time. The host can load HI or LO directly through write strobes.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI and LO are zero, `busy` is low and `req_ready` is high.
- R2: Opcode 0 (signed multiply) sign-extends both operands and writes the 64-bit product, upper half to HI and lower half to LO, at the acceptance edge.
- R3: Opcode 1 (unsigned multiply) zero-extends both operands and writes the 64-bit product to HI:LO.
- R4: Opcodes 2 (signed) and 3 (unsigned) add the product to the current HI:LO value, with carry passing from LO into HI, and write the 64-bit sum back.
- R5: Opcodes 4 (signed) and 5 (unsigned) subtract the product from the current HI:LO value and write the 64-bit difference back.
- R6: Opcode 6 (signed divide) writes the quotient, truncated toward zero, to LO and the remainder, which carries the dividend's sign, to HI.
- R7: A divide whose divisor is zero runs its full length and leaves HI and LO unchanged, with no error indication.
- R8: Dividing 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R9: An accepted divide holds `busy` high, and `req_ready` low, for exactly 33 cycles. Its result is visible when `busy` falls. A multiply never raises `busy`.
- R10: A request presented while `busy` is high is not lost. It is accepted on the first edge after `busy` falls, and its result appears as usual.
- R11: `hi_we` loads HI from `wr_data` and `lo_we` loads LO from `wr_data`, but only when `busy` is low and no request is accepted in the same cycle. At any other time the strobes have no effect.
- R12: Opcode 7 is accepted like any other request and leaves HI and LO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 3 | Operation code |
| req_a | input | 32 | First operand (multiplicand or dividend) |
| req_b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | A divide is in progress |
| hi_we | input | 1 | Direct write strobe for HI |
| lo_we | input | 1 | Direct write strobe for LO |
| wr_data | input | 32 | Data for direct writes |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |

## Verification
The assertions run on every cycle and cover the following:
- a divide raises `busy` on the next cycle and a multiply does not;
- a `busy` stretch never exceeds 33 cycles;
- HI and LO stay frozen while a divide is in flight, so host strobes during that time have no effect;
- a zero-divisor divide ends with HI and LO equal to their values at acceptance.

Only the bench scenarios can show the following:
- the arithmetic values, including the carry and borrow between LO and HI and the sign of quotient and remainder;
- the most-negative case;
- the exact 33-cycle busy length;
- that a stalled request is taken once the divide ends;
- that an accepted request wins over a host write in the same cycle.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  typedef enum logic [2:0] {
    OP_MULS  = 3'd0,
    OP_MULU  = 3'd1,
    OP_MADDS = 3'd2,
    OP_MADDU = 3'd3,
    OP_MSUBS = 3'd4,
    OP_MSUBU = 3'd5,
    OP_DIVS  = 3'd6,
    OP_NOP   = 3'd7
  } op_t;

  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_RUN  = 2'd1,
    DV_FIX  = 2'd2
  } div_state_t;

endpackage

// File: rtl/hilo_mac.sv
// Combinational product and accumulate stage for the HI:LO pair.
module hilo_mac
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  op_t            op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [2*W-1:0] acc_i,
  output logic [2*W-1:0] res_o
);

  localparam int PW = 2 * W;

  logic           sgn;
  logic [PW-1:0]  ext_a;
  logic [PW-1:0]  ext_b;
  logic [PW-1:0]  prod;

  always_comb begin
    sgn = (op_i == OP_MULS) || (op_i == OP_MADDS) || (op_i == OP_MSUBS);
  end

  // The low 2W bits of the product of two extended operands are the same
  // for signed and unsigned interpretation, so one multiplier serves both.
  assign ext_a = {{W{sgn & a_i[W-1]}}, a_i};
  assign ext_b = {{W{sgn & b_i[W-1]}}, b_i};
  assign prod  = ext_a * ext_b;

  always_comb begin
    unique case (op_i)
      OP_MULS, OP_MULU:   res_o = prod;
      OP_MADDS, OP_MADDU: res_o = acc_i + prod;
      OP_MSUBS, OP_MSUBU: res_o = acc_i - prod;
      default:            res_o = acc_i;
    endcase
  end

endmodule

// File: rtl/hilo_div.sv
// Iterative signed divider: one quotient bit per cycle on magnitudes,
// followed by one sign fix-up cycle.
module hilo_div
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         zero_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  localparam int CW = $clog2(W) + 1;

  div_state_t     st;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   part;
  logic [W-1:0]   quo;
  logic [W-1:0]   dvs;
  logic           neg_q;
  logic           neg_r;
  logic           zero_q;

  logic [W:0]     shifted;
  logic [W:0]     trial;
  logic [W-1:0]   mag_dvd;
  logic [W-1:0]   mag_dvs;

  assign mag_dvd = dvd_i[W-1] ? (~dvd_i + 1'b1) : dvd_i;
  assign mag_dvs = dvs_i[W-1] ? (~dvs_i + 1'b1) : dvs_i;

  assign shifted = {part, quo[W-1]};
  assign trial   = shifted - {1'b0, dvs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= DV_IDLE;
      cnt    <= '0;
      part   <= '0;
      quo    <= '0;
      dvs    <= '0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      unique case (st)
        DV_IDLE: begin
          if (start_i) begin
            st     <= DV_RUN;
            cnt    <= CW'(W);
            part   <= '0;
            quo    <= mag_dvd;
            dvs    <= mag_dvs;
            neg_q  <= dvd_i[W-1] ^ dvs_i[W-1];
            neg_r  <= dvd_i[W-1];
            zero_q <= (dvs_i == '0);
          end
        end
        DV_RUN: begin
          if (!trial[W]) begin
            part <= trial[W-1:0];
            quo  <= {quo[W-2:0], 1'b1};
          end else begin
            part <= shifted[W-1:0];
            quo  <= {quo[W-2:0], 1'b0};
          end
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= DV_FIX;
        end
        DV_FIX:  st <= DV_IDLE;
        default: st <= DV_IDLE;
      endcase
    end
  end

  assign busy_o = (st != DV_IDLE);
  assign done_o = (st == DV_FIX);
  assign zero_o = zero_q;
  assign quo_o  = neg_q ? (~quo + 1'b1) : quo;
  assign rem_o  = neg_r ? (~part + 1'b1) : part;

endmodule

// File: rtl/hilo_muldiv.sv
// HI/LO multiply-accumulate-divide unit, top level.
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [2:0]   req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         busy,
  input  logic         hi_we,
  input  logic         lo_we,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);

  op_t            op;
  logic           accept;
  logic           div_start;
  logic           mac_write;
  logic           div_busy;
  logic           div_done;
  logic           div_zero;
  logic [W-1:0]   div_q;
  logic [W-1:0]   div_r;
  logic [2*W-1:0] mac_res;
  logic [W-1:0]   hi_q;
  logic [W-1:0]   lo_q;

  assign op        = op_t'(req_op);
  assign req_ready = !div_busy;
  assign accept    = req_valid && req_ready;
  assign div_start = accept && (op == OP_DIVS);
  assign mac_write = accept && (op != OP_DIVS) && (op != OP_NOP);

  hilo_mac #(.W(W)) mac_i (
    .op_i  (op),
    .a_i   (req_a),
    .b_i   (req_b),
    .acc_i ({hi_q, lo_q}),
    .res_o (mac_res)
  );

  hilo_div #(.W(W)) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start),
    .dvd_i   (req_a),
    .dvs_i   (req_b),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .zero_o  (div_zero),
    .quo_o   (div_q),
    .rem_o   (div_r)
  );

  // Precedence: divide completion, then accepted operation, then host strobes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (div_done) begin
      if (!div_zero) begin
        hi_q <= div_r;
        lo_q <= div_q;
      end
    end else if (mac_write) begin
      hi_q <= mac_res[2*W-1:W];
      lo_q <= mac_res[W-1:0];
    end else if (!div_busy && !accept) begin
      if (hi_we) hi_q <= wr_data;
      if (lo_we) lo_q <= wr_data;
    end
  end

  assign busy = div_busy;
  assign hi   = hi_q;
  assign lo   = lo_q;

endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [2:0]   req_op,
  input logic [W-1:0] req_b,
  input logic         busy,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);

  localparam int BW = $clog2(W) + 2;

  logic          acc;
  logic [BW-1:0] bcnt;
  logic          zpend;
  logic [W-1:0]  sv_hi;
  logic [W-1:0]  sv_lo;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt  <= '0;
      zpend <= 1'b0;
      sv_hi <= '0;
      sv_lo <= '0;
    end else begin
      bcnt <= busy ? bcnt + 1'b1 : '0;
      if (acc && req_op == 3'd6 && req_b == '0) begin
        zpend <= 1'b1;
        sv_hi <= hi;
        sv_lo <= lo;
      end else if (zpend && !busy) begin
        zpend <= 1'b0;
      end
    end
  end

  p_div_raises_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 3'd6) |=> busy);

  p_mul_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op != 3'd6) |=> !busy);

  p_busy_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt <= BW'(W)));

  p_frozen_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hi) && $stable(lo)));

  p_zero_div_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (zpend && !busy) |-> (hi == sv_hi && lo == sv_lo));

endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_b     (req_b),
  .busy      (busy),
  .hi        (hi),
  .lo        (lo)
);

// File: tb/hilo_muldiv_tb_top.sv
module hilo_muldiv_tb_top;

  typedef struct packed {
    logic [7:0]  rq;
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] ih;
    logic [31:0] il;
    logic [31:0] eh;
    logic [31:0] el;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // R2 signed multiply
    '{8'd2,  3'd0, 32'hFFFFFFFD, 32'd7,        32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFEB},
    '{8'd2,  3'd0, 32'h80000000, 32'h80000000, 32'h0, 32'h0, 32'h40000000, 32'h00000000},
    // R3 unsigned multiply
    '{8'd3,  3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'hFFFFFFFE, 32'h00000001},
    '{8'd3,  3'd1, 32'h80000000, 32'd2,        32'h5, 32'h5, 32'h00000001, 32'h00000000},
    // R4 multiply-add
    '{8'd4,  3'd2, 32'hFFFFFFFE, 32'd3,        32'h0, 32'd10, 32'h0, 32'd4},
    '{8'd4,  3'd3, 32'd1,        32'd1,        32'h0, 32'hFFFFFFFF, 32'h1, 32'h0},
    // R5 multiply-subtract
    '{8'd5,  3'd4, 32'd2,        32'd3,        32'h0, 32'd5, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{8'd5,  3'd5, 32'hFFFFFFFF, 32'd1,        32'h1, 32'h0, 32'h0, 32'h1},
    // R6 signed divide, all sign combinations
    '{8'd6,  3'd6, 32'd7,        32'd2,        32'h0, 32'h0, 32'd1, 32'd3},
    '{8'd6,  3'd6, 32'hFFFFFFF9, 32'd2,        32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFD},
    '{8'd6,  3'd6, 32'd7,        32'hFFFFFFFE, 32'h0, 32'h0, 32'd1, 32'hFFFFFFFD},
    '{8'd6,  3'd6, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'h0, 32'h0, 32'hFFFFFFFF, 32'd3},
    // R8 most negative over minus one
    '{8'd8,  3'd6, 32'h80000000, 32'hFFFFFFFF, 32'h7, 32'h7, 32'h0, 32'h80000000},
    // R7 divide by zero
    '{8'd7,  3'd6, 32'd5,        32'd0,        32'h12345678, 32'h9ABCDEF0, 32'h12345678, 32'h9ABCDEF0},
    // R12 reserved opcode
    '{8'd12, 3'd7, 32'd9,        32'd9,        32'hAAAA5555, 32'h0F0F0F0F, 32'hAAAA5555, 32'h0F0F0F0F}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [31:0] req_a = '0;
  logic [31:0] req_b = '0;
  logic        busy;
  logic        hi_we = 1'b0;
  logic        lo_we = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] hi;
  logic [31:0] lo;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hilo_muldiv #(.W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .busy(busy),
    .hi_we(hi_we), .lo_we(lo_we), .wr_data(wr_data), .hi(hi), .lo(lo)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic load(input logic [31:0] h, input logic [31:0] l);
    @(negedge clk); hi_we = 1'b1; wr_data = h;
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b1; wr_data = l;
    @(negedge clk); lo_we = 1'b0;
  endtask

  // Presents a request at a falling edge and holds it until accepted.
  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=hang expected=completion");
    finish_run();
  end

  initial begin
    int bcount;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hi:lo", {hi, lo}, 64'h0);
    check("R1 busy,ready", {62'h0, busy, req_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i].ih, VEC[i].il);
      @(negedge clk);
      issue(VEC[i].op, VEC[i].a, VEC[i].b);
      wait_idle();
      check($sformatf("R%0d vector %0d", VEC[i].rq, i), {hi, lo}, {VEC[i].eh, VEC[i].el});
    end

    // R11 direct write when idle
    load(32'hCAFE0001, 32'hBEEF0002);
    check("R11 idle write", {hi, lo}, 64'hCAFE0001_BEEF0002);

    // R9 busy length and ready low while busy; multiply leaves busy low
    @(negedge clk);
    issue(3'd6, 32'd100, 32'd7);
    bcount = 0;
    while (busy) begin
      if (req_ready) begin
        n_chk++; n_bad++;
        $display("FAIL R9 ready while busy actual=1 expected=0");
      end
      bcount++;
      @(negedge clk);
    end
    check("R9 busy cycles", 64'(bcount), 64'd33);
    check("R9 div result", {hi, lo}, {32'd2, 32'd14});
    issue(3'd1, 32'd6, 32'd7);
    check("R9 mult no busy", {63'h0, busy}, 64'h0);
    check("R9 mult result", {hi, lo}, 64'd42);

    // R11 strobes ignored during a divide (zero divisor keeps HI/LO)
    load(32'h11, 32'h22);
    issue(3'd6, 32'd5, 32'd0);
    hi_we = 1'b1; lo_we = 1'b1; wr_data = 32'hDEAD;
    wait_idle();
    hi_we = 1'b0; lo_we = 1'b0;
    @(negedge clk);
    check("R11 write while busy", {hi, lo}, {32'h11, 32'h22});

    // R11 accepted request wins over same-cycle write
    req_valid = 1'b1; req_op = 3'd0; req_a = 32'd2; req_b = 32'd3;
    hi_we = 1'b1; lo_we = 1'b1; wr_data = 32'hFFFF;
    @(negedge clk);
    req_valid = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    check("R11 request beats write", {hi, lo}, 64'd6);

    // R10 request held while busy is taken afterwards
    issue(3'd6, 32'd9, 32'd4);
    req_valid = 1'b1; req_op = 3'd1; req_a = 32'd3; req_b = 32'd5;
    @(negedge clk);
    check("R10 stalled while busy", {62'h0, busy, req_ready}, 64'h2);
    while (!req_ready) @(negedge clk);
    check("R10 divide result first", {hi, lo}, {32'd1, 32'd2});
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 held request done", {hi, lo}, 64'd15);

    finish_run();
  end

endmodule